// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass and returns the 16-bit sum and the carry-out. Each bit first forms a generate/propagate pair. A carry-in of one is merged into the pair at bit 0 before the network starts. A tree of prefix cells then reduces the pairs into group pairs that each start at bit 0. The group generate that ends at bit j is the carry into bit j+1. Each sum bit is the XOR of its propagate signal and its incoming carry. The carry-out is the group generate over the whole word.

Every prefix cell takes a lower (less significant) pair and an upper pair. It returns an output generate equal to the upper generate OR (upper propagate AND lower generate), and an output propagate equal to the AND of both propagates. Swapping the two cell inputs gives a wrong result, so each cell keeps its inputs in bit order.

A parameter selects one of three prefix graphs:
- the sparse up-and-down sweep, with 26 cells;
- the dense full-fan graph, with 49 cells in 4 levels;
- a mixed graph, with 32 cells in 5 levels. It pairs neighbouring bits first, runs the dense graph on the eight odd-position groups, and then fills in the even positions with one last row.

All three graphs share the same cell and stage framework, so a designer can compare their depth and size.

Top module: `hpa_prefix_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination, with the default mixed topology (`TOPO = TOPO_HY`, encoding 2).
- R2: `carry_out` equals bit 16 of the 17-bit total `op_a + op_b + carry_in`.
- R3: When every bit position propagates (`op_a ^ op_b` is all ones) and `carry_in` is 1, `sum_out` is 0 and `carry_out` is 1. The carry crosses all 16 positions.
- R4: When every bit position propagates and `carry_in` is 0, `sum_out` is all ones and `carry_out` is 0.
- R5: A carry generated at bit 0 only (`op_a = 1`, `op_b = 16'hFFFF`, `carry_in = 0`) reaches the carry-out, and `sum_out` is 0.
- R6: With the sweep topology (`TOPO_BK`, encoding 0), `sum_out` and `carry_out` meet R1 and R2 on the same inputs.
- R7: With the dense topology (`TOPO_KS`, encoding 1), `sum_out` and `carry_out` meet R1 and R2 on the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bench drives identical vectors into three copies of the block, one for each topology. It compares each copy against its own arithmetic total.

Random operands with a random carry-in exercise the typical mixes of generate, kill and propagate positions. Some corner patterns make every position propagate, both with and without a carry-in. These separate a network that carries a group across the full width from one that drops a long span. A single generate at bit 0 under an all-propagate field separates correct operand order in the cells from swapped order. The zero and all-ones operands check the two ends of the range.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    typedef enum logic [1:0] {
        TOPO_BK = 2'd0,
        TOPO_KS = 2'd1,
        TOPO_HY = 2'd2
    } topo_e;

    // Number of cell rows needed by each topology for 2**lg inputs.
    function automatic int stage_count(topo_e t, int lg);
        int n;
        unique case (t)
            TOPO_BK: n = 2 * lg - 1;
            TOPO_KS: n = lg;
            default: n = lg + 1;
        endcase
        return n;
    endfunction

    // Distance back to the lower operand of the cell at (row s, bit i);
    // zero means the position is passed through unchanged on that row.
    function automatic int cell_span(topo_e t, int s, int i, int lg);
        int d;
        int lv;
        d = 0;
        unique case (t)
            TOPO_KS: begin
                if (i >= (1 << s)) d = 1 << s;
            end
            TOPO_BK: begin
                if (s < lg) begin
                    if (((i + 1) % (2 << s)) == 0) d = 1 << s;
                end else begin
                    lv = 2 * lg - 2 - s;
                    if ((((i + 1) % (2 << lv)) == (1 << lv)) && (i >= (2 << lv)))
                        d = 1 << lv;
                end
            end
            default: begin
                if (s == 0) begin
                    if ((i % 2) == 1) d = 1;
                end else if (s < lg) begin
                    if (((i % 2) == 1) && (i >= (1 << s) + 1)) d = 1 << s;
                end else begin
                    if (((i % 2) == 0) && (i >= 2)) d = 1;
                end
            end
        endcase
        return d;
    endfunction

    // Total number of prefix cells a topology instantiates.
    function automatic int cell_total(topo_e t, int w, int lg);
        int n;
        n = 0;
        for (int s = 0; s < stage_count(t, lg); s++)
            for (int i = 0; i < w; i++)
                if (cell_span(t, s, i, lg) != 0) n++;
        return n;
    endfunction

endpackage

// File: rtl/hpa_bit_pg.sv
module hpa_bit_pg #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] gen_bit,
    output logic [WIDTH-1:0] prop_bit
);
    logic [WIDTH-1:0] raw_gen;

    assign raw_gen  = op_a & op_b;
    assign prop_bit = op_a ^ op_b;

    // Carry-in enters as extra generate at the lowest position.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_low
                assign gen_bit[i] = raw_gen[i] | (prop_bit[i] & carry_in);
            end else begin : g_rest
                assign gen_bit[i] = raw_gen[i];
            end
        end
    endgenerate
endmodule

// File: rtl/hpa_gp_cell.sv
module hpa_gp_cell (
    input  logic g_lo,
    input  logic p_lo,
    input  logic g_hi,
    input  logic p_hi,
    output logic g_out,
    output logic p_out
);
    // Upper operand dominates; order of operands must not be swapped.
    assign g_out = g_hi | (p_hi & g_lo);
    assign p_out = p_hi & p_lo;
endmodule

// File: rtl/hpa_prefix_net.sv
module hpa_prefix_net
    import hpa_pkg::*;
#(
    parameter int    WIDTH = 16,
    parameter topo_e TOPO  = TOPO_HY
) (
    input  logic [WIDTH-1:0] g_in,
    input  logic [WIDTH-1:0] p_in,
    output logic [WIDTH-1:0] g_pre,
    output logic [WIDTH-1:0] p_pre
);
    localparam int LG     = $clog2(WIDTH);
    localparam int NSTAGE = stage_count(TOPO, LG);
    localparam int NCELL  = cell_total(TOPO, WIDTH, LG);

    logic [WIDTH-1:0] g_row [0:NSTAGE];
    logic [WIDTH-1:0] p_row [0:NSTAGE];

    assign g_row[0] = g_in;
    assign p_row[0] = p_in;

    generate
        for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
            for (genvar i = 0; i < WIDTH; i++) begin : g_pos
                localparam int SPAN = cell_span(TOPO, s, i, LG);
                if (SPAN != 0) begin : g_cell
                    hpa_gp_cell u_cell (
                        .g_lo  (g_row[s][i-SPAN]),
                        .p_lo  (p_row[s][i-SPAN]),
                        .g_hi  (g_row[s][i]),
                        .p_hi  (p_row[s][i]),
                        .g_out (g_row[s+1][i]),
                        .p_out (p_row[s+1][i])
                    );
                end else begin : g_pass
                    assign g_row[s+1][i] = g_row[s][i];
                    assign p_row[s+1][i] = p_row[s][i];
                end
            end
        end
    endgenerate

    assign g_pre = g_row[NSTAGE];
    assign p_pre = p_row[NSTAGE];

    // Group propagate from bit 0 must equal the AND of all bit propagates (R1).
    always_comb begin
        logic run_and;
        run_and = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            run_and = run_and & p_in[i];
            p_prefix_prop_r1: assert (p_pre[i] == run_and)
                else $error("prefix propagate mismatch at bit %0d", i);
        end
    end
endmodule

// File: rtl/hpa_prefix_adder.sv
module hpa_prefix_adder
    import hpa_pkg::*;
#(
    parameter int    WIDTH = 16,
    parameter topo_e TOPO  = TOPO_HY
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    logic [WIDTH-1:0] gen_bit;
    logic [WIDTH-1:0] prop_bit;
    logic [WIDTH-1:0] g_pre;
    logic [WIDTH-1:0] p_pre;
    logic [WIDTH-1:0] carry_vec;

    hpa_bit_pg #(.WIDTH(WIDTH)) u_pg (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .gen_bit  (gen_bit),
        .prop_bit (prop_bit)
    );

    hpa_prefix_net #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
        .g_in  (gen_bit),
        .p_in  (prop_bit),
        .g_pre (g_pre),
        .p_pre (p_pre)
    );

    // Carry into bit i is the group generate ending at bit i-1.
    assign carry_vec = {g_pre[WIDTH-2:0], carry_in};
    assign sum_out   = prop_bit ^ carry_vec;
    assign carry_out = g_pre[WIDTH-1];

    always_comb begin
        logic [WIDTH:0] total;
        total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        p_sum_match_r1: assert (sum_out == total[WIDTH-1:0])
            else $error("sum mismatch");
        p_cout_match_r2: assert (carry_out == total[WIDTH])
            else $error("carry-out mismatch");
        if (((op_a ^ op_b) == {WIDTH{1'b1}}) && carry_in) begin
            p_full_carry_r3: assert (carry_out && (sum_out == '0))
                else $error("carry lost across propagate field");
        end
        if (((op_a ^ op_b) == {WIDTH{1'b1}}) && !carry_in) begin
            p_no_carry_r4: assert (!carry_out && (sum_out == {WIDTH{1'b1}}))
                else $error("spurious carry in propagate field");
        end
    end
endmodule

// File: tb/hpa_prefix_adder_tb.sv
module hpa_prefix_adder_tb;
    import hpa_pkg::*;

    localparam int W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] s_hy, s_bk, s_ks;
    logic         c_hy, c_bk, c_ks;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    hpa_prefix_adder #(.WIDTH(W), .TOPO(TOPO_HY)) u_dut (
        .op_a(a), .op_b(b), .carry_in(cin), .sum_out(s_hy), .carry_out(c_hy));
    hpa_prefix_adder #(.WIDTH(W), .TOPO(TOPO_BK)) u_dut_bk (
        .op_a(a), .op_b(b), .carry_in(cin), .sum_out(s_bk), .carry_out(c_bk));
    hpa_prefix_adder #(.WIDTH(W), .TOPO(TOPO_KS)) u_dut_ks (
        .op_a(a), .op_b(b), .carry_in(cin), .sum_out(s_ks), .carry_out(c_ks));

    function automatic logic [W:0] ref_total(logic [W-1:0] x, logic [W-1:0] y, logic ci);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    endfunction

    task automatic check(string req, logic [W:0] got, logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)", req, got, exp, a, b, cin);
        end
    endtask

    // Applies one vector and checks all three topologies.
    task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic ci, string tag_hy);
        logic [W:0] e;
        @(posedge clk);
        a = x; b = y; cin = ci;
        #1;
        e = ref_total(x, y, ci);
        check({tag_hy, " R1 sum"},  {1'b0, s_hy}, {1'b0, e[W-1:0]});
        check({tag_hy, " R2 cout"}, {W'(0), c_hy}, {W'(0), e[W]});
        check("R6 sweep",  {c_bk, s_bk}, e);
        check("R7 dense",  {c_ks, s_ks}, e);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        void'($urandom(32'd1234));
        // zero inputs
        apply(16'h0000, 16'h0000, 1'b0, "zero");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "max");
        // R3: full propagate with carry-in
        apply(16'hFFFF, 16'h0000, 1'b1, "R3");
        @(posedge clk); #1;
        checks++;
        if (!(s_hy == '0 && c_hy)) begin
            errors++;
            $display("FAIL R3: got %b_%h expected 1_0000", c_hy, s_hy);
        end
        apply(16'hA5A5, 16'h5A5A, 1'b1, "R3");
        // R4: full propagate without carry-in
        apply(16'hA5A5, 16'h5A5A, 1'b0, "R4");
        checks++;
        if (!(s_hy == 16'hFFFF && !c_hy)) begin
            errors++;
            $display("FAIL R4: got %b_%h expected 0_ffff", c_hy, s_hy);
        end
        apply(16'h0F0F, 16'hF0F0, 1'b0, "R4");
        // R5: generate at bit 0 only
        apply(16'h0001, 16'hFFFF, 1'b0, "R5");
        checks++;
        if (!(s_hy == '0 && c_hy)) begin
            errors++;
            $display("FAIL R5: got %b_%h expected 1_0000", c_hy, s_hy);
        end
        apply(16'hFFFF, 16'h0001, 1'b0, "R5");
        // single-bit walking generates under a propagate field
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] one;
            one = W'(1) << k;
            apply(one, ~one | one, 1'b0, "walk");
            apply(one, ~one, 1'b1, "walk");
        end
        // random
        for (int n = 0; n < 400; n++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "rand");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule